// File: doc/BRIEF.md
# Compound-Adder Rounding Selector

This block finishes the addition of two aligned, unsigned floating-point significands. The larger operand arrives unshifted. The smaller one arrives already shifted right, and the bits it lost in that shift come with it as three low-order flags: guard, round and sticky. The block builds two candidate sums side by side: the plain sum and the sum plus one. Rounding then comes down to a two-way choice made from the low bits, using round-to-nearest with ties to even. There is no separate incrementer after the adder.

When the sum carries out of the significand width, the result must move right by one place. The block handles this without a third candidate. The plus-one candidate is, in effect, an increment at the position just below the new LSB. A round-up in that case needs that bit to be 1, so the carry ripples into the shifted LSB. The outputs are the rounded significand, a flag that tells the exponent logic to add one, and an inexact flag. The path is combinational, with an optional output register selected by parameter.

Top module: `rnd_sel`

## Requirements
- R1: With no carry out of `a_sig + b_sig`, the output is the low `SIG_W` bits of the sum, plus one exactly when `grd`=1 and at least one of `rnd`, `stk` or the sum's bit 0 is 1.
- R2: An exact halfway case rounds to even. With no carry, this is `grd`=1, `rnd`=0, `stk`=0. With a carry, it is sum bit 0 = 1 and `grd`, `rnd`, `stk` all 0. In both cases the output's bit 0 is 0.
- R3: When the sum carries out, `exp_inc` is 1 and the output is bits `SIG_W`..1 of the sum. The sum's bit 0 serves as the guard bit, and the OR of `grd`, `rnd` and `stk` serves as the sticky bit. The output is incremented exactly when the guard bit is 1 and at least one of the sticky bit or the output LSB is 1.
- R4: If the sum has no carry, its low `SIG_W` bits are all ones, and R1 calls for a round-up, the output is a 1 in the MSB with all other bits zero, and `exp_inc` is 1.
- R5: `inexact` is 1 exactly when some discarded bit is nonzero. With no carry, that is any of `grd`, `rnd`, `stk`. With a carry, it is any of those or the sum's bit 0.
- R6: With `OUT_REG`=1, the outputs appear one clock after the inputs and are all zero while `rst_n` is low. With `OUT_REG`=0, they follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sig | input | SIG_W | Larger aligned significand |
| b_sig | input | SIG_W | Smaller significand after alignment shift |
| grd | input | 1 | First bit shifted out of `b_sig` |
| rnd | input | 1 | Second bit shifted out of `b_sig` |
| stk | input | 1 | OR of all further bits shifted out |
| sig_out | output | SIG_W | Rounded significand |
| exp_inc | output | 1 | Exponent must be incremented by one |
| inexact | output | 1 | Result differs from the exact sum |

## Verification
The assertions assume that the inputs hold steady from one rising edge to the next. They make no other assumption about the inputs: any pair of unsigned significands with any guard, round and sticky pattern is legal. The bench changes inputs only on falling edges. Random operands are drawn both with the MSB forced high, which makes carry-out common, and with no constraint, which gives the no-carry case. Directed patterns hit the all-ones wrap and exact ties in both the carry and no-carry cases.

// File: rtl/rnd_sel.sv
module rnd_sel #(
  parameter int SIG_W   = 24,
  parameter bit OUT_REG = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SIG_W-1:0] a_sig,
  input  logic [SIG_W-1:0] b_sig,
  input  logic             grd,
  input  logic             rnd,
  input  logic             stk,
  output logic [SIG_W-1:0] sig_out,
  output logic             exp_inc,
  output logic             inexact
);

  localparam int SW = SIG_W + 1;

  logic [SW-1:0]    sum0, sum1;
  logic             cy0, low_ones;
  logic             g_eff, s_eff, lsb_eff, up;
  logic [SIG_W-1:0] sig_c;
  logic             exp_c, inx_c;

  // compound adder: both candidates formed in parallel
  assign sum0 = {1'b0, a_sig} + {1'b0, b_sig};
  assign sum1 = {1'b0, a_sig} + {1'b0, b_sig} + SW'(1);
  assign cy0  = sum0[SIG_W];
  assign low_ones = &sum0[SIG_W-1:0];

  // rounding bits seen from the final LSB position
  assign g_eff   = cy0 ? sum0[0] : grd;
  assign s_eff   = cy0 ? (grd | rnd | stk) : (rnd | stk);
  assign lsb_eff = cy0 ? sum0[1] : sum0[0];
  assign up      = g_eff & (s_eff | lsb_eff);

  // select: on carry both candidates are read one place higher
  always_comb begin
    if (cy0)
      sig_c = up ? sum1[SIG_W:1] : sum0[SIG_W:1];
    else if (up && sum1[SIG_W])
      sig_c = sum1[SIG_W:1];
    else
      sig_c = up ? sum1[SIG_W-1:0] : sum0[SIG_W-1:0];
  end

  assign exp_c = cy0 | (up & sum1[SIG_W]);
  assign inx_c = g_eff | s_eff;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sig_out <= '0;
          exp_inc <= 1'b0;
          inexact <= 1'b0;
        end else begin
          sig_out <= sig_c;
          exp_inc <= exp_c;
          inexact <= inx_c;
        end
      end

      a_r6_reg_latency: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sig_out == $past(sig_c)) && (exp_inc == $past(exp_c)) && (inexact == $past(inx_c)));
    end else begin : g_comb
      assign sig_out = sig_c;
      assign exp_inc = exp_c;
      assign inexact = inx_c;
    end
  endgenerate

  // R1 / R3: an exact result takes the plain-sum candidate unchanged
  a_r1_exact_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    (!grd && !rnd && !stk && !(cy0 && sum0[0])) |->
      (sig_c == (cy0 ? sum0[SIG_W:1] : sum0[SIG_W-1:0])) && !inx_c);

  // R2: ties land on an even significand
  a_r2_tie_even: assert property (@(posedge clk) disable iff (!rst_n)
    ((!cy0 && grd && !rnd && !stk) || (cy0 && sum0[0] && !grd && !rnd && !stk)) |->
      !sig_c[0]);

  // R3: any exponent bump leaves a normalized significand
  a_r3_msb_on_inc: assert property (@(posedge clk) disable iff (!rst_n)
    exp_c |-> sig_c[SIG_W-1]);

  // R4: rounding an all-ones sum wraps to 1.000...0
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cy0 && low_ones && grd && (rnd || stk || sum0[0])) |->
      exp_c && (sig_c == {1'b1, {(SIG_W-1){1'b0}}}));

endmodule

// File: tb/sim_rnd_sel.sv
module sim_rnd_sel;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_sig = '0, b_sig = '0;
  logic         grd = 1'b0, rnd = 1'b0, stk = 1'b0;
  logic [W-1:0] sig_out;
  logic         exp_inc, inexact;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rnd_sel #(.SIG_W(W), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .a_sig(a_sig), .b_sig(b_sig),
    .grd(grd), .rnd(rnd), .stk(stk),
    .sig_out(sig_out), .exp_inc(exp_inc), .inexact(inexact)
  );

  // exact integer rounding, sum scaled by 8 to keep G,R,S
  function automatic logic [W+1:0] ref_rnd(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic g, input logic r, input logic s);
    logic [W+3:0] full;
    logic [W:0]   keep;
    logic [3:0]   rem, half;
    logic         e, up;
    full = {1'b0, a, 3'b000} + {1'b0, b, 3'b000} + {{(W+1){1'b0}}, g, r, s};
    if (full[W+3]) begin
      keep = {1'b0, full[W+3:4]}; rem = full[3:0]; half = 4'd8; e = 1'b1;
    end else begin
      keep = {1'b0, full[W+2:3]}; rem = {1'b0, full[2:0]}; half = 4'd4; e = 1'b0;
    end
    up = (rem > half) || ((rem == half) && keep[0]);
    keep = keep + {{W{1'b0}}, up};
    if (keep[W]) begin
      keep = keep >> 1;
      e = 1'b1;
    end
    return {e, (rem != 4'd0), keep[W-1:0]};
  endfunction

  task automatic apply_check(input logic [W-1:0] a, input logic [W-1:0] b,
                             input logic g, input logic r, input logic s);
    logic [W+1:0] exp_v;
    logic [W:0]   raw;
    string        tag;
    @(negedge clk);
    a_sig = a; b_sig = b; grd = g; rnd = r; stk = s;
    @(posedge clk);
    #1;
    exp_v = ref_rnd(a, b, g, r, s);
    raw = {1'b0, a} + {1'b0, b};
    if (raw[W]) tag = (raw[0] && !g && !r && !s) ? "R2" : "R3";
    else if (exp_v[W+1]) tag = "R4";
    else if (g && !r && !s) tag = "R2";
    else tag = "R1";
    checks++;
    if ({exp_inc, sig_out} !== {exp_v[W+1], exp_v[W-1:0]}) begin
      fails++;
      $display("FAIL %s a=%h b=%h grs=%b%b%b got inc=%b sig=%h exp inc=%b sig=%h",
               tag, a, b, g, r, s, exp_inc, sig_out, exp_v[W+1], exp_v[W-1:0]);
    end
    checks++;
    if (inexact !== exp_v[W]) begin
      fails++;
      $display("FAIL R5 a=%h b=%h grs=%b%b%b got inexact=%b exp %b",
               a, b, g, r, s, inexact, exp_v[W]);
    end
  endtask

  initial begin : watchdog
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [W-1:0] ra, rb;
    logic [2:0]   rg;
    void'($urandom(32'h1234_5678));
    a_sig = 24'hFFFFFF; b_sig = 24'h000001; grd = 1'b1; rnd = 1'b1; stk = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checks++;  // R6 reset clears outputs
    if ({sig_out, exp_inc, inexact} !== '0) begin
      fails++;
      $display("FAIL R6 reset got sig=%h inc=%b inx=%b exp all zero", sig_out, exp_inc, inexact);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 no-carry cases
    apply_check(24'h400000, 24'h000010, 1'b0, 1'b0, 1'b0);
    apply_check(24'h400000, 24'h000010, 1'b1, 1'b0, 1'b1);
    apply_check(24'h400000, 24'h000010, 1'b0, 1'b1, 1'b1);
    // R2 ties, no carry: even stays, odd rounds up
    apply_check(24'h400000, 24'h000010, 1'b1, 1'b0, 1'b0);
    apply_check(24'h400000, 24'h000011, 1'b1, 1'b0, 1'b0);
    // R2 tie with carry, both parities of the new LSB
    apply_check(24'h800000, 24'h800001, 1'b0, 1'b0, 1'b0);
    apply_check(24'h800002, 24'h800001, 1'b0, 1'b0, 1'b0);
    // R3 carry: sticky from the old G/R/S
    apply_check(24'h800000, 24'h800001, 1'b0, 1'b0, 1'b1);
    apply_check(24'hFFFFFF, 24'hFFFFFF, 1'b1, 1'b1, 1'b1);
    apply_check(24'hC00000, 24'hC00000, 1'b1, 1'b0, 1'b0);
    // R4 all-ones wrap
    apply_check(24'hFFFFF0, 24'h00000F, 1'b1, 1'b1, 1'b0);
    apply_check(24'hFFFFFE, 24'h000001, 1'b1, 1'b0, 1'b0);
    apply_check(24'hFFFFFE, 24'h000001, 1'b0, 1'b1, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      ra = W'($urandom);
      rb = W'($urandom);
      rg = 3'($urandom);
      if (i % 3 == 0) begin ra[W-1] = 1'b1; rb[W-1] = 1'b1; end
      if (i % 7 == 0) rg = 3'b100;
      apply_check(ra, rb, rg[2], rg[1], rg[0]);
    end

    // R6 reset mid-run clears the register
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    checks++;
    if ({sig_out, exp_inc, inexact} !== '0) begin
      fails++;
      $display("FAIL R6 mid reset got sig=%h inc=%b inx=%b exp all zero", sig_out, exp_inc, inexact);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule